// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Router

This block accepts 32-bit writes to a single send register and converts each one into an interrupt-set request for exactly one processor core. The written word carries both the destination core and the interrupt vector. The block pulls out the 10-bit core identifier and the 5-bit vector. It expands the vector into a 32-bit one-hot mask. It then raises a one-clock set strobe on the line of the addressed core, together with that mask, so that the core's status bank can OR the mask into its pending bits.

Every write is acknowledged one clock after it is accepted. If the identifier names a core at or above the configured core count, the acknowledge carries a decode-error flag. In that case no set strobe is raised and the mask bus stays zero. The identifier maps directly to the core index. The core count is a parameter of at least 1 and at most 1024, the range that a 10-bit identifier can address. The per-core status registers and any mailbox traffic belong to neighbouring blocks.

Top module: `ipi_send_router`

## Requirements
- R1: Every cycle with `wr_valid` high produces `wr_ack` high in exactly the next cycle. A cycle without a write produces no acknowledge in the next cycle.
- R2: The destination core index is bits 25:16 of `wr_data`, read as an unsigned 10-bit number.
- R3: The vector is bits 4:0 of `wr_data`. On a routed write, `set_mask` equals `1 << vector`, with exactly one bit set.
- R4: A write whose index is below `NUM_CORES` raises `set_valid[index]` alone, for one cycle only, in the same cycle as `wr_ack`. `wr_err` is low in that cycle.
- R5: A write whose index is at or above `NUM_CORES` raises `wr_err` with `wr_ack`. `set_valid` is all zero and `set_mask` is zero in that cycle.
- R6: Bits 15:5 and 31:26 of `wr_data` have no effect on any output.
- R7: While `rst_n` is low, and in the first cycle after reset with no write, all outputs are zero.
- R8: Back-to-back writes in consecutive cycles are each routed independently, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe for the send register |
| wr_data | input | 32 | Written send word |
| wr_ack | output | 1 | Write completion, one cycle after the write |
| wr_err | output | 1 | Decode error, valid with `wr_ack` |
| set_valid | output | NUM_CORES | One-hot set strobe per core |
| set_mask | output | 32 | One-hot vector mask for the strobed core |

## Verification
Every result register is loaded from a single write and cleared one cycle later. A wrong index, a wrong vector bit or a stale strobe therefore shows up at the ports in the cycle right after the write. It shows as a wrong `set_valid` bit, a mask bit at the wrong position, or a strobe or error that lasts into a second cycle. Random writes scramble the ignored bit fields and place identifiers on both sides of the core-count limit. Directed cases cover the first core, the last core, the first missing index, the highest identifier, both vector ends, and a stream of writes in consecutive cycles.

// File: rtl/ipi_router_pkg.sv
package ipi_router_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ID_W    = 10;
  localparam int unsigned ID_LSB  = 16;
  localparam int unsigned VEC_W   = 5;
  localparam int unsigned VEC_N   = 1 << VEC_W;

  typedef logic [ID_W-1:0]  core_id_t;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [VEC_N-1:0] vec_mask_t;

  typedef struct packed {
    core_id_t core_id;
    vec_t     vec;
  } send_fields_t;
endpackage

// File: rtl/ipi_field_decode.sv
module ipi_field_decode
  import ipi_router_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output send_fields_t      fields_o
);
  // Only the identifier and vector fields are picked; all other bits are dropped.
  always_comb begin
    fields_o.core_id = word_i[ID_LSB +: ID_W];
    fields_o.vec     = word_i[VEC_W-1:0];
  end
endmodule

// File: rtl/ipi_vec_onehot.sv
module ipi_vec_onehot
  import ipi_router_pkg::*;
(
  input  vec_t      vec_i,
  output vec_mask_t mask_o
);
  for (genvar b = 0; b < VEC_N; b++) begin : g_bit
    assign mask_o[b] = (vec_i == VEC_W'(b));
  end
endmodule

// File: rtl/ipi_core_select.sv
module ipi_core_select
  import ipi_router_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  core_id_t             core_id_i,
  output logic [NUM_CORES-1:0] hit_o,
  output logic                 in_range_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign hit_o[c] = (core_id_i == ID_W'(c));
  end

  assign in_range_o = |hit_o;

  always_comb begin
    AST_HIT_SINGLE: assert ($onehot0(hit_o)); // R4
  end
endmodule

// File: rtl/ipi_send_router.sv
module ipi_send_router
  import ipi_router_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [31:0]          wr_data,
  output logic                 wr_ack,
  output logic                 wr_err,
  output logic [NUM_CORES-1:0] set_valid,
  output logic [31:0]          set_mask
);
  send_fields_t          fields;
  vec_mask_t             onehot;
  logic [NUM_CORES-1:0]  hit;
  logic                  in_range;

  logic                  ack_d, ack_q;
  logic                  err_d, err_q;
  logic [NUM_CORES-1:0]  sel_d, sel_q;
  vec_mask_t             mask_d, mask_q;

  ipi_field_decode u_decode (
    .word_i   (wr_data),
    .fields_o (fields)
  );

  ipi_vec_onehot u_onehot (
    .vec_i  (fields.vec),
    .mask_o (onehot)
  );

  ipi_core_select #(.NUM_CORES(NUM_CORES)) u_select (
    .core_id_i  (fields.core_id),
    .hit_o      (hit),
    .in_range_o (in_range)
  );

  // Next-state: a write loads the result, an idle cycle clears it.
  always_comb begin
    ack_d  = 1'b0;
    err_d  = 1'b0;
    sel_d  = '0;
    mask_d = '0;
    if (wr_valid) begin
      ack_d = 1'b1;
      err_d = ~in_range;
      if (in_range) begin
        sel_d  = hit;
        mask_d = onehot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      sel_q  <= '0;
      mask_q <= '0;
    end else begin
      ack_q  <= ack_d;
      err_q  <= err_d;
      sel_q  <= sel_d;
      mask_q <= mask_d;
    end
  end

  assign wr_ack    = ack_q;
  assign wr_err    = err_q;
  assign set_valid = sel_q;
  assign set_mask  = mask_q;

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> wr_ack); // R1
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !wr_ack); // R1
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_valid) |-> $onehot(set_mask)); // R3
  AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_valid)); // R4
  AST_SET_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_valid) |-> (wr_ack && !wr_err)); // R4
  AST_ERR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (wr_ack && set_valid == '0 && set_mask == '0)); // R5
endmodule

// File: tb/tb_ipi_send_router.sv
module tb_ipi_send_router;
  localparam int unsigned N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_valid;
  logic [31:0]  wr_data;
  logic         wr_ack;
  logic         wr_err;
  logic [N-1:0] set_valid;
  logic [31:0]  set_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ipi_send_router #(.NUM_CORES(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_err(wr_err), .set_valid(set_valid), .set_mask(set_mask)
  );

  function automatic logic [N-1:0] exp_sel(input logic [31:0] d);
    int id = int'(d[25:16]);
    return (id < N) ? (N'(1) << id) : '0;
  endfunction

  function automatic logic [31:0] exp_mask(input logic [31:0] d);
    return (int'(d[25:16]) < N) ? (32'd1 << d[4:0]) : 32'd0;
  endfunction

  function automatic logic exp_err(input logic [31:0] d);
    return int'(d[25:16]) >= N;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [31:0] d);
    check({req, " ack"},  64'(wr_ack), 64'd1);
    check({req, " err"},  64'(wr_err), 64'(exp_err(d)));
    check({req, " sel"},  64'(set_valid), 64'(exp_sel(d)));
    check({req, " mask"}, 64'(set_mask), 64'(exp_mask(d)));
  endtask

  task automatic check_idle(input string req);
    check({req, " idle ack"},  64'(wr_ack), 64'd0);
    check({req, " idle err"},  64'(wr_err), 64'd0);
    check({req, " idle sel"},  64'(set_valid), 64'd0);
    check({req, " idle mask"}, 64'(set_mask), 64'd0);
  endtask

  // Single write, then one idle cycle: the result shows after the edge, then clears.
  task automatic send(input string req, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = $urandom;
    check_result(req, d);
    @(negedge clk);
    check_idle({req, " R1 R4"});
  endtask

  function automatic logic [31:0] mk(input int id, input int vec, input logic [31:0] junk);
    logic [31:0] w = junk;
    w[25:16] = id[9:0];
    w[4:0]   = vec[4:0];
    return w;
  endfunction

  initial begin
    wr_valid = 1'b0;
    wr_data  = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R7 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R7 after reset");

    send("R2 R3 R4 core0 vec0", mk(0, 0, 32'h0));
    send("R2 R3 R4 last core vec31", mk(N-1, 31, 32'h0));
    send("R5 first missing index", mk(N, 7, 32'h0));
    send("R5 highest id", mk(1023, 31, 32'h0));
    send("R6 junk bits core1", mk(1, 9, 32'hFC00_FFE0));
    send("R6 junk bits core2", mk(2, 17, 32'hA5A5_5A5A));

    // R8: consecutive writes, each result one cycle later.
    begin
      logic [31:0] prev;
      prev = 'x;
      for (int i = 0; i < 6; i++) begin
        logic [31:0] d;
        @(negedge clk);
        if (i > 0) check_result("R8 back-to-back", prev);
        d = mk(i % (N + 2), i * 5, $urandom);
        wr_valid = 1'b1;
        wr_data  = d;
        prev = d;
      end
      @(negedge clk);
      wr_valid = 1'b0;
      check_result("R8 back-to-back last", prev);
      @(negedge clk);
      check_idle("R8 R1 drain");
    end

    // R1: no write, no acknowledge, over several idle cycles with noisy data.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr_data = $urandom;
      check_idle("R1 no write");
    end

    // Random writes, identifiers biased around the core-count limit.
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d = $urandom;
      if (i % 2 == 0) d[25:16] = 10'($urandom_range(0, N + 2));
      send("R2 R3 R4 R5 R6 random", d);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule